// File: doc/BRIEF.md
# Dual Time-of-Day Alarm with Interrupt

This block holds two independent alarms and compares them against a running BCD calendar time. Each alarm has five field registers: seconds, minutes, hours, date and month. Every field register carries its own enable bit. Only the enabled fields take part in a comparison, and a field whose enable bit is clear is ignored.

An alarm is evaluated only when the second-tick strobe is high. It fires only when its arm bit is set, at least one of its fields is enabled, and every enabled field equals the current time. A firing alarm sets its status bit, and that bit stays set until the host clears it.

The block drives an active-low interrupt line in one of two modes:
- Level mode: the line stays asserted while either status bit is set.
- Pulse mode: every firing produces a low pulse of fixed length.

The host reaches all registers through a flat address/data port. Writes take effect at the clock edge, and reads are combinational.

Top module: `dual_alarm_irq`

## Requirements
- R1: After reset, all field registers, the control register and the status register read 0, and `irq_n` is high.
- R2: Each field register holds a match value in bits 6:0 and its match enable in bit 7. Alarm 0 fields sit at 1Dh..21h and alarm 1 fields sit at 23h..27h, in the order seconds, minutes, hours, date, month. All of them read back what was written. An unmapped address reads 0.
- R3: A comparison happens only in a cycle with `sec_tick` high. When an armed alarm's enabled fields all equal the current time, its status bit reads 1 from the next cycle.
- R4: A field with bit 7 clear is a don't-care. An alarm with no field enabled never fires.
- R5: The control register at 0Eh holds the arm bits: bit 0 arms alarm 0 and bit 1 arms alarm 1. An alarm whose arm bit is 0 never fires.
- R6: The status register at 0Fh holds alarm 0 in bit 0 and alarm 1 in bit 1. Writing 0 to a bit clears it, and writing 1 to a bit leaves it unchanged.
- R7: If an alarm fires in the same cycle as a host write that clears its status bit, the bit remains 1.
- R8: With control bit 2 at 0 (level mode), `irq_n` is low whenever either status bit is 1. It is high only when both are 0.
- R9: With control bit 2 at 1 (pulse mode), a firing drives `irq_n` low for exactly PULSE_W cycles, starting in the cycle after the tick.
- R10: With only the seconds field enabled, an alarm fires exactly once per minute of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_date | input | 7 | Current day of month, BCD |
| cur_month | input | 7 | Current month, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |

## Verification
Two functions can fall in the same cycle: an alarm setting its status bit on a tick, and the host writing 0 to clear that bit. The bench provokes this in two steps. First it makes both status bits 1. Then it raises `sec_tick`, with a time that matches only alarm 0, in the same cycle as a status write of zero. It judges the outcome by reading the status register afterwards. The bit of the matching alarm must survive, and the bit of the other alarm must be cleared. A checker also asserts that any firing leaves its bit set in the following cycle, regardless of host writes.

// File: rtl/dual_alarm_pkg.sv
// Shared types for the dual alarm block.
// Assumes BCD time fields fit in 7 bits; bit 7 of a field register is its enable.
package dual_alarm_pkg;
    localparam int NFIELD = 5;       // sec, min, hour, date, month
    localparam int EN_BIT = 7;
    typedef logic [7:0] fld_t;
    typedef logic [6:0] bcd_t;
endpackage

// File: rtl/alarm_unit.sv
// One alarm: NFIELD field registers at consecutive addresses from BASE, plus
// a masked comparator. Assumes cur_time index 0 is seconds.
// match is combinational and is qualified by tick/arm outside this module.
module alarm_unit
    import dual_alarm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BASE   = 'h1D
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  fld_t                    wdata,
    input  bcd_t [NFIELD-1:0]       cur_time,
    output fld_t [NFIELD-1:0]       fields,
    output logic                    match
);
    fld_t               fld_q [NFIELD];
    logic [NFIELD-1:0]  fld_eq;
    logic [NFIELD-1:0]  fld_en;

    for (genvar f = 0; f < NFIELD; f++) begin : g_fld
        localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(BASE + f);

        // Holds one field register, written by the host at its own address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fld_q[f] <= '0;
            else if (wr_en && addr == FADDR)
                fld_q[f] <= wdata;
        end

        // Per-field compare: a disabled field always agrees.
        always_comb begin
            fld_en[f] = fld_q[f][EN_BIT];
            fld_eq[f] = !fld_en[f] || (fld_q[f][6:0] == cur_time[f]);
        end

        assign fields[f] = fld_q[f];
    end

    // An alarm with nothing enabled must never match.
    assign match = (&fld_eq) && (|fld_en);
endmodule

// File: rtl/irq_gen.sv
// Interrupt shaper: level mode follows the status request, pulse mode
// stretches each firing to PULSE_W cycles. A new firing reloads the count.
module irq_gen #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_mode,
    input  logic fire,
    input  logic level_req,
    output logic irq_n
);
    localparam int CW = $clog2(PULSE_W + 1);
    localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

    logic [CW-1:0] cnt_q;

    // Pulse-length down-counter, loaded on every firing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (fire)
            cnt_q <= LOAD;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Output mode select.
    assign irq_n = pulse_mode ? (cnt_q == '0) : !level_req;
endmodule

// File: rtl/dual_alarm_irq.sv
// Top of the dual alarm block: two alarm units, control and status
// registers, read mux and interrupt shaper. Assumes sec_tick lasts one cycle.
module dual_alarm_irq
    import dual_alarm_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int A0_BASE   = 'h1D,
    parameter int A1_BASE   = 'h23,
    parameter int CTRL_ADDR = 'h0E,
    parameter int STAT_ADDR = 'h0F,
    parameter int PULSE_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [6:0]        cur_hour,
    input  logic [6:0]        cur_date,
    input  logic [6:0]        cur_month,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq_n
);
    localparam int NALM = 2;
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    bcd_t [NFIELD-1:0]  cur_time;
    fld_t [NFIELD-1:0]  alm_fields [NALM];
    logic [NALM-1:0]    alm_match;
    logic [NALM-1:0]    hit;
    logic [NALM-1:0]    status_q;
    logic [NALM-1:0]    status_d;
    logic [NALM:0]      ctrl_q;     // [1:0] arm bits, [2] pulse mode
    logic               clr_wr;

    assign cur_time = {cur_month, cur_date, cur_hour, cur_min, cur_sec};

    for (genvar a = 0; a < NALM; a++) begin : g_alm
        alarm_unit #(
            .ADDR_W (ADDR_W),
            .BASE   (a == 0 ? A0_BASE : A1_BASE)
        ) u_alarm (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr),
            .addr     (reg_addr),
            .wdata    (reg_wdata),
            .cur_time (cur_time),
            .fields   (alm_fields[a]),
            .match    (alm_match[a])
        );
    end

    // Firing: tick-qualified, armed match.
    assign hit    = {NALM{sec_tick}} & ctrl_q[NALM-1:0] & alm_match;
    assign clr_wr = reg_wr && reg_addr == STAT_A;

    // Status next state: write-0 clears, a firing in the same cycle wins.
    always_comb begin
        for (int a = 0; a < NALM; a++)
            status_d[a] = hit[a] | (status_q[a] & !(clr_wr && !reg_wdata[a]));
    end

    // Status and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            ctrl_q   <= '0;
        end else begin
            status_q <= status_d;
            if (reg_wr && reg_addr == CTRL_A)
                ctrl_q <= reg_wdata[NALM:0];
        end
    end

    // Combinational read mux; unmapped addresses return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CTRL_A)
            reg_rdata = 8'(ctrl_q);
        if (reg_addr == STAT_A)
            reg_rdata = 8'(status_q);
        for (int f = 0; f < NFIELD; f++) begin
            if (reg_addr == ADDR_W'(A0_BASE + f))
                reg_rdata = alm_fields[0][f];
            if (reg_addr == ADDR_W'(A1_BASE + f))
                reg_rdata = alm_fields[1][f];
        end
    end

    irq_gen #(
        .PULSE_W (PULSE_W)
    ) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_mode (ctrl_q[NALM]),
        .fire       (|hit),
        .level_req  (|status_q),
        .irq_n      (irq_n)
    );
endmodule

// Property checker for dual_alarm_irq; observes status, firing and irq_n.
module dual_alarm_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic [1:0] hit,
    input logic [1:0] status,
    input logic       pulse_mode,
    input logic       irq_n
);
    // R3
    no_fire_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |-> hit == 2'b00);
    // R3
    status_rise_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> (status & ~$past(status)) == 2'b00);
    // R7
    fire_sets_status0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |=> status[0]);
    // R7
    fire_sets_status1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |=> status[1]);
    // R8
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && status != 2'b00) |-> !irq_n);
    // R8
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && status == 2'b00) |-> irq_n);
    // R9
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && hit != 2'b00) |=> (!irq_n || !pulse_mode));
endmodule

bind dual_alarm_irq dual_alarm_irq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_tick   (sec_tick),
    .hit        (hit),
    .status     (status_q),
    .pulse_mode (ctrl_q[2]),
    .irq_n      (irq_n)
);

// File: tb/dual_alarm_irq_bench.sv
module dual_alarm_irq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0, cur_month = '0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_alarm_irq #(.PULSE_W(PW)) u_dual_alarm_irq (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_date(cur_date), .cur_month(cur_month),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_n(irq_n)
    );

    // Vector: {sec, min, hour, month, expected status {a1,a0}}.
    // Alarm 0 = sec 30 + min 15 enabled; alarm 1 = hour 08 + month 03 enabled.
    localparam logic [29:0] VEC [6] = '{
        {7'h30, 7'h15, 7'h08, 7'h03, 2'b11},
        {7'h30, 7'h15, 7'h09, 7'h03, 2'b01},
        {7'h31, 7'h15, 7'h08, 7'h03, 2'b10},
        {7'h30, 7'h14, 7'h23, 7'h03, 2'b00},
        {7'h30, 7'h15, 7'h08, 7'h04, 2'b01},
        {7'h00, 7'h15, 7'h08, 7'h03, 2'b10}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_time(input logic [6:0] s, m, h, mo);
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = 7'h12; cur_month = mo;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    function automatic logic [6:0] bcd(input int v);
        return 7'((v / 10) * 16 + (v % 10));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int hits;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(6'h1D, v); check("R1 a0 sec", v, 8'h00);
        rd(6'h27, v); check("R1 a1 month", v, 8'h00);
        rd(6'h0E, v); check("R1 ctrl", v, 8'h00);
        rd(6'h0F, v); check("R1 status", v, 8'h00);
        check("R1 irq_n", {7'b0, irq_n}, 8'h01);

        // configure
        wr(6'h1D, 8'hB0); wr(6'h1E, 8'h95);
        wr(6'h25, 8'h88); wr(6'h27, 8'h83);
        wr(6'h0E, 8'h03);

        // R2: readback and unmapped
        rd(6'h1D, v); check("R2 a0 sec", v, 8'hB0);
        rd(6'h1E, v); check("R2 a0 min", v, 8'h95);
        rd(6'h27, v); check("R2 a1 month", v, 8'h83);
        rd(6'h23, v); check("R2 a1 sec", v, 8'h00);
        rd(6'h22, v); check("R2 unmapped", v, 8'h00);

        // R3: matching time without tick does nothing
        set_time(7'h30, 7'h15, 7'h08, 7'h03);
        repeat (3) @(negedge clk);
        rd(6'h0F, v); check("R3 no tick", v, 8'h00);

        // Vector walk (R3, R4, R8)
        for (int i = 0; i < 6; i++) begin
            set_time(VEC[i][29:23], VEC[i][22:16], VEC[i][15:9], VEC[i][8:2]);
            tick();
            rd(6'h0F, v); check($sformatf("R3 vec%0d status", i), v, {6'b0, VEC[i][1:0]});
            check($sformatf("R8 vec%0d irq", i), {7'b0, irq_n}, {7'b0, VEC[i][1:0] == 2'b00});
            wr(6'h0F, 8'h00);
            check($sformatf("R8 vec%0d cleared irq", i), {7'b0, irq_n}, 8'h01);
        end

        // R5: alarm 0 disarmed
        wr(6'h0E, 8'h02);
        set_time(7'h30, 7'h15, 7'h08, 7'h03);
        tick();
        rd(6'h0F, v); check("R5 disarmed", v, 8'h02);
        wr(6'h0F, 8'h00);
        wr(6'h0E, 8'h03);

        // R6/R8: write-1 no effect, partial clear keeps irq low
        wr(6'h0F, 8'h03);
        rd(6'h0F, v); check("R6 write one", v, 8'h00);
        tick();
        wr(6'h0F, 8'h02);
        rd(6'h0F, v); check("R6 partial clear", v, 8'h02);
        check("R8 one bit left", {7'b0, irq_n}, 8'h00);
        wr(6'h0F, 8'h00);
        check("R8 both clear", {7'b0, irq_n}, 8'h01);

        // R7: firing vs clear in the same cycle
        tick();
        set_time(7'h30, 7'h15, 7'h09, 7'h03);
        reg_wr = 1'b1; reg_addr = 6'h0F; reg_wdata = 8'h00; sec_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; sec_tick = 1'b0;
        rd(6'h0F, v); check("R7 collision", v, 8'h01);
        wr(6'h0F, 8'h00);

        // R9: pulse mode
        wr(6'h0E, 8'h07);
        set_time(7'h30, 7'h15, 7'h08, 7'h03);
        tick();
        for (int k = 0; k < PW + 2; k++) begin
            check($sformatf("R9 pulse cycle %0d", k), {7'b0, irq_n}, {7'b0, k >= PW});
            @(negedge clk);
        end
        wr(6'h0F, 8'h00);

        // R4: alarm 0 with no field enabled never fires
        wr(6'h0E, 8'h01);
        wr(6'h1D, 8'h00); wr(6'h1E, 8'h00);
        set_time(7'h00, 7'h00, 7'h00, 7'h00);
        cur_date = 7'h00;
        tick();
        rd(6'h0F, v); check("R4 none enabled", v, 8'h00);

        // R10: seconds-only alarm 1 over two minutes of ticks
        wr(6'h25, 8'h00); wr(6'h27, 8'h00); wr(6'h23, 8'h85);
        wr(6'h0E, 8'h02);
        hits = 0;
        for (int i = 0; i < 120; i++) begin
            set_time(bcd(i % 60), bcd(i / 60), 7'h08, 7'h03);
            tick();
            rd(6'h0F, v);
            if (v[1]) begin
                hits++;
                wr(6'h0F, 8'h00);
            end
        end
        check("R10 once per minute", 8'(hits), 8'd2);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule